// File: doc/BRIEF.md
# Platform Reset Control Sequencer

The block holds a small software-writable control byte and a sequencer that drives the platform's active-low reset lines. Software writes the byte through a simple I/O write strobe and reads it back combinationally. When the trigger bit goes from 0 to 1, the select bit chooses between two actions. One is a short processor-init pulse (a soft reset). The other is a long platform reset with suspend status asserted (a hard reset). With the full-reset enable set, the hard path instead becomes a full power cycle. In a full power cycle the three sleep-state lines are driven low for a long window. Platform reset is held through that window and for a tail delay after the sleep lines return high.

Two external fault events can also start a hard reset or a full power cycle: a falling power-good input, and the second of two watchdog timeout pulses. A falling power-good or a second timeout starts a full power cycle when the full-reset enable is set, and a plain hard reset when it is clear. Every duration is a parameter counted in clock cycles. A busy output covers each active sequence. While busy is high, register writes and fault events are ignored.

Top module: `plat_rst_seq`

## Requirements
- R1: After reset the control byte reads 00h, `init_n`, `plat_rst_n`, `susp_n` and all three `slp_n` lines are high, and `busy` is low.
- R2: A write stores bit 3 (full-reset enable), bit 2 (trigger) and bit 1 (hard select). Bits 7:4 and bit 0 are discarded and always read back as 0.
- R3: A write that takes bit 2 from 0 to 1 with bit 1 = 0 drives `init_n` low for exactly SOFT_CYC cycles, starting the cycle after the write. All other reset and sleep outputs stay high.
- R4: A write with bit 2 = 1 while the stored bit 2 is already 1 starts no sequence.
- R5: A trigger with bit 1 = 1 and bit 3 = 0 drives `plat_rst_n` and `susp_n` low for exactly HARD_CYC cycles. The `slp_n` lines stay high.
- R6: Starting a hard reset or a full power cycle, from any cause, returns the control byte to 00h.
- R7: A trigger with bit 1 = 1 and bit 3 = 1 drives all three `slp_n` lines low together for FULL_CYC cycles. `plat_rst_n` and `susp_n` are held low for FULL_CYC + TAIL_CYC cycles.
- R8: A 1-to-0 transition of `pwr_good` starts a full power cycle (as R7) if the stored bit 3 is 1, and a hard reset (as R5) if it is 0.
- R9: The first `wdt_tmo` pulse only arms a watchdog count. The second pulse starts the same action as R8. The count is cleared when any sequence completes.
- R10: `busy` is high for every cycle of a sequence. Writes that arrive while busy leave the control byte unchanged and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Register write strobe, one cycle per write |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Current control byte |
| pwr_good | input | 1 | Power-good level; a falling edge is a fault |
| wdt_tmo | input | 1 | Watchdog timeout pulse |
| init_n | output | 1 | Processor init, active low |
| plat_rst_n | output | 1 | Platform reset, active low |
| susp_n | output | 1 | Suspend status, active low |
| slp_n | output | 3 | Sleep-state lines, active low |
| busy | output | 1 | A sequence is active |

## Verification
The bench builds the block with SOFT_CYC = 16, HARD_CYC = 7, FULL_CYC = 11 and TAIL_CYC = 4. These short windows let every sequence run to completion many times in a short run. The bench sweeps all sixteen combinations of the low nibble, with the reserved high bits set in their complement pattern. For each combination it computes the expected phase lengths and the read-back value arithmetically. Fault starts under both settings of the enable, the two-count watchdog with its clear, and writes arriving mid-sequence are each run separately.

// File: rtl/plat_rst_pkg.sv
package plat_rst_pkg;
  localparam int CTL_W  = 8;
  localparam int NUM_SLP = 3;
  localparam int B_FULL = 3;
  localparam int B_TRIG = 2;
  localparam int B_HARD = 1;
  localparam logic [CTL_W-1:0] CTL_MASK = 8'h0E;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SOFT  = 3'd1,
    ST_HARD  = 3'd2,
    ST_SLEEP = 3'd3,
    ST_TAIL  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/plat_rst_reg.sv
module plat_rst_reg
  import plat_rst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [CTL_W-1:0] io_wdata,
  input  logic             busy,
  input  logic             clr_hard,
  output logic [CTL_W-1:0] ctl_q,
  output logic             wr_start,
  output logic             wr_hard,
  output logic             wr_full
);
  logic             wr_ok;
  logic [CTL_W-1:0] ctl_d;
  logic             ctl_en;

  assign wr_ok    = io_wr & ~busy;
  assign wr_start = wr_ok & io_wdata[B_TRIG] & ~ctl_q[B_TRIG];
  assign wr_hard  = io_wdata[B_HARD];
  assign wr_full  = io_wdata[B_FULL];

  always_comb begin
    ctl_en = clr_hard | wr_ok;
    ctl_d  = ctl_q;
    if (clr_hard)   ctl_d = '0;
    else if (wr_ok) ctl_d = io_wdata & CTL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  // R10: a write during an active sequence leaves the byte untouched
  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_q));
endmodule

// File: rtl/plat_rst_evt.sv
module plat_rst_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic wdt_tmo,
  input  logic busy,
  input  logic seq_done,
  output logic fault
);
  logic pg_q;
  logic wd_arm_q;
  logic wd_arm_d;
  logic pg_fall;

  assign pg_fall = pg_q & ~pwr_good;
  assign fault   = ~busy & (pg_fall | (wdt_tmo & wd_arm_q));

  always_comb begin
    wd_arm_d = wd_arm_q;
    if (seq_done)     wd_arm_d = 1'b0;
    else if (wdt_tmo) wd_arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q     <= 1'b0;
      wd_arm_q <= 1'b0;
    end else begin
      pg_q     <= pwr_good;
      wd_arm_q <= wd_arm_d;
    end
  end

  // R9: the first timeout never starts a sequence on its own
  p_first_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_tmo && !wd_arm_q && !(pg_q && !pwr_good)) |-> !fault);
endmodule

// File: rtl/plat_rst_fsm.sv
module plat_rst_fsm
  import plat_rst_pkg::*;
#(
  parameter int SOFT_CYC = 16,
  parameter int HARD_CYC = 180000,
  parameter int FULL_CYC = 132000000,
  parameter int TAIL_CYC = 33000,
  parameter int CW       = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_soft,
  input  logic               go_hard,
  input  logic               go_full,
  output logic               busy,
  output logic               seq_done,
  output logic               init_n,
  output logic               plat_rst_n,
  output logic               susp_n,
  output logic [NUM_SLP-1:0] slp_n
);
  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last     = (cnt_q == '0);
  assign busy     = (st_q != ST_IDLE);
  assign seq_done = busy & last & (st_q != ST_SLEEP);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (go_full) begin
          st_d  = ST_SLEEP;
          cnt_d = CW'(FULL_CYC - 1);
        end else if (go_hard) begin
          st_d  = ST_HARD;
          cnt_d = CW'(HARD_CYC - 1);
        end else if (go_soft) begin
          st_d  = ST_SOFT;
          cnt_d = CW'(SOFT_CYC - 1);
        end
      end
      ST_SLEEP: begin
        if (last) begin
          st_d  = ST_TAIL;
          cnt_d = CW'(TAIL_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (last) st_d = ST_IDLE;
        else      cnt_d = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign init_n     = (st_q != ST_SOFT);
  assign plat_rst_n = !(st_q == ST_HARD || st_q == ST_SLEEP || st_q == ST_TAIL);
  assign susp_n     = plat_rst_n;

  for (genvar g = 0; g < NUM_SLP; g++) begin : g_slp
    assign slp_n[g] = (st_q != ST_SLEEP);
  end

  // R3: the soft pulse never overlaps platform reset or sleep
  p_soft_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> (plat_rst_n && (&slp_n)));
  // R3: the init pulse lasts more than one cycle
  p_soft_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_n) |=> !init_n);
  // R7: sleep lines low implies platform reset held
  p_sleep_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_n[0] |-> (!plat_rst_n && busy));
  // R10: busy stays up until the sequence completes
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy);
endmodule

// File: rtl/plat_rst_seq.sv
module plat_rst_seq
  import plat_rst_pkg::*;
#(
  parameter int SOFT_CYC = 16,
  parameter int HARD_CYC = 180000,
  parameter int FULL_CYC = 132000000,
  parameter int TAIL_CYC = 33000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic [CTL_W-1:0]   io_wdata,
  output logic [CTL_W-1:0]   io_rdata,
  input  logic               pwr_good,
  input  logic               wdt_tmo,
  output logic               init_n,
  output logic               plat_rst_n,
  output logic               susp_n,
  output logic [NUM_SLP-1:0] slp_n,
  output logic               busy
);
  localparam int MAX_AB = (SOFT_CYC > HARD_CYC) ? SOFT_CYC : HARD_CYC;
  localparam int MAX_CD = (FULL_CYC > TAIL_CYC) ? FULL_CYC : TAIL_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAX_C) + 1;

  logic [CTL_W-1:0] ctl_q;
  logic wr_start, wr_hard, wr_full;
  logic fault, seq_done;
  logic go_soft, go_hard, go_full;

  assign go_full = fault ? ctl_q[B_FULL]  : (wr_start & wr_hard & wr_full);
  assign go_hard = fault ? ~ctl_q[B_FULL] : (wr_start & wr_hard & ~wr_full);
  assign go_soft = ~fault & wr_start & ~wr_hard;
  assign io_rdata = ctl_q;

  plat_rst_reg u_reg (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_wdata(io_wdata),
    .busy(busy), .clr_hard(go_hard | go_full), .ctl_q(ctl_q),
    .wr_start(wr_start), .wr_hard(wr_hard), .wr_full(wr_full)
  );

  plat_rst_evt u_evt (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wdt_tmo(wdt_tmo),
    .busy(busy), .seq_done(seq_done), .fault(fault)
  );

  plat_rst_fsm #(
    .SOFT_CYC(SOFT_CYC), .HARD_CYC(HARD_CYC),
    .FULL_CYC(FULL_CYC), .TAIL_CYC(TAIL_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_soft(go_soft), .go_hard(go_hard),
    .go_full(go_full), .busy(busy), .seq_done(seq_done), .init_n(init_n),
    .plat_rst_n(plat_rst_n), .susp_n(susp_n), .slp_n(slp_n)
  );

  // R6: a hard or full start leaves the byte cleared
  p_hard_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (go_hard || go_full)) |=> (ctl_q == '0));
endmodule

// File: tb/plat_rst_seq_tb.sv
module plat_rst_seq_tb;
  localparam int CLK_P = 10;
  localparam int SC = 16, HC = 7, FC = 11, TC = 4;

  logic       clk, rst_n, io_wr, pwr_good, wdt_tmo;
  logic [7:0] io_wdata, io_rdata;
  logic       init_n, plat_rst_n, susp_n, busy;
  logic [2:0] slp_n;

  int n_chk, n_bad;
  int c_busy, c_init, c_plat, c_susp, c_slp, c_mis;

  plat_rst_seq #(.SOFT_CYC(SC), .HARD_CYC(HC), .FULL_CYC(FC), .TAIL_CYC(TC)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .pwr_good(pwr_good), .wdt_tmo(wdt_tmo),
    .init_n(init_n), .plat_rst_n(plat_rst_n), .susp_n(susp_n),
    .slp_n(slp_n), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    io_wr = 1'b1; io_wdata = v;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic meas();
    int g;
    c_busy = 0; c_init = 0; c_plat = 0; c_susp = 0; c_slp = 0; c_mis = 0;
    g = 0;
    while (busy && g < 1000) begin
      c_busy++;
      if (!init_n) c_init++;
      if (!plat_rst_n) c_plat++;
      if (!susp_n) c_susp++;
      if (!slp_n[0]) c_slp++;
      if (slp_n != 3'b000 && slp_n != 3'b111) c_mis++;
      g++;
      @(negedge clk);
    end
  endtask

  task automatic chk_seq(input string req, input int eb, input int ei,
                         input int ep, input int es);
    chk({req, " busy"}, c_busy, eb);
    chk({req, " init"}, c_init, ei);
    chk({req, " plat"}, c_plat, ep);
    chk({req, " susp"}, c_susp, ep);
    chk({req, " slp"},  c_slp,  es);
    chk({req, " slp_mismatch"}, c_mis, 0);
  endtask

  task automatic quiet(input string req, input int n);
    int q = 0;
    for (int k = 0; k < n; k++) begin
      if (busy || !init_n || !plat_rst_n || slp_n != 3'b111) q++;
      @(negedge clk);
    end
    chk(req, q, 0);
  endtask

  initial begin : wdog
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; io_wr = 1'b0; io_wdata = '0; pwr_good = 1'b1; wdt_tmo = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", int'(io_rdata), 0);
    chk("R1 outs", int'({init_n, plat_rst_n, susp_n, slp_n}), 6'h3F);
    chk("R1 busy", int'(busy), 0);

    // Sweep of the low nibble: R2 R3 R5 R6 R7
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      int eb, ei, ep, es, er;
      v = {~i[3:0], i[3:0]};
      wr(8'h00);
      wr(v);
      meas();
      ei = 0; ep = 0; es = 0; er = int'(v & 8'h0E);
      if (v[2]) begin
        if (!v[1]) ei = SC;
        else if (!v[3]) ep = HC;
        else begin ep = FC + TC; es = FC; end
        if (v[1]) er = 0;
      end
      eb = ei + ep;
      if (!v[2]) chk_seq("R2 no-trigger", eb, ei, ep, es);
      else if (!v[1]) chk_seq("R3 soft", eb, ei, ep, es);
      else if (!v[3]) chk_seq("R5 hard", eb, ei, ep, es);
      else chk_seq("R7 full", eb, ei, ep, es);
      if (v[2] && v[1]) chk("R6 cleared", int'(io_rdata), er);
      else chk("R2 readback", int'(io_rdata), er);
    end

    // R10 write during busy is ignored
    wr(8'h00);
    wr(8'h04);
    c_busy = 0;
    while (busy && c_busy < 1000) begin
      c_busy++;
      io_wr = (c_busy == 5);
      io_wdata = 8'h0A;
      @(negedge clk);
    end
    io_wr = 1'b0;
    chk("R10 busy len", c_busy, SC);
    chk("R10 rdata", int'(io_rdata), 8'h04);
    quiet("R10 no restart", 4);

    // R4 trigger already set
    wr(8'h04);
    quiet("R4 no restart", 6);
    wr(8'h00);
    wr(8'h04);
    meas();
    chk_seq("R4 rearmed", SC, SC, 0, 0);

    // R8 power-good fall, enable clear then set
    wr(8'h00);
    pwr_good = 1'b0;
    @(negedge clk);
    pwr_good = 1'b1;
    meas();
    chk_seq("R8 pg hard", HC, 0, HC, 0);
    quiet("R8 pg rise", 3);
    wr(8'h08);
    pwr_good = 1'b0;
    @(negedge clk);
    pwr_good = 1'b1;
    meas();
    chk_seq("R8 pg full", FC + TC, 0, FC + TC, FC);
    chk("R8 R6 rdata", int'(io_rdata), 0);

    // R9 watchdog two-count
    wr(8'h08);
    wdt_tmo = 1'b1; @(negedge clk); wdt_tmo = 1'b0;
    quiet("R9 first tmo", 4);
    wdt_tmo = 1'b1; @(negedge clk); wdt_tmo = 1'b0;
    meas();
    chk_seq("R9 second tmo", FC + TC, 0, FC + TC, FC);
    wdt_tmo = 1'b1; @(negedge clk); wdt_tmo = 1'b0;
    quiet("R9 cleared count", 4);
    wdt_tmo = 1'b1; @(negedge clk); wdt_tmo = 1'b0;
    meas();
    chk_seq("R9 hard tmo", HC, 0, HC, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule